// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block places incoming frames into host memory through a circular list of 16-byte descriptors. Each descriptor carries a status word (word 0), a tag word the engine leaves untouched (word 1), and the buffer address (word 2; word 3 holds upper address bits that this 32-bit engine ignores). Software fills in a descriptor, sets its ownership bit and writes the buffer capacity into the status word. The engine then copies one whole frame into that buffer and writes the status back with ownership cleared.

Frames arrive as a byte stream with a ready/valid handshake, a last-byte marker and an error flag. Memory traffic uses a simple master port that carries a word address. The port holds a request until the memory acknowledges it, and has per-byte write enables. The descriptor pointer advances by 16 bytes after each frame. It returns to the ring base after a descriptor whose end-of-ring bit is set. When the current descriptor still belongs to software, the engine discards the arriving frame and counts it as missed.

Top module: `rx_ring_engine`

## Requirements
- R1: For each frame the engine first reads the status word at descriptor word offset 0 and then, if owned, the buffer byte address at word offset 2 (bits 1:0 of that address are ignored).
- R2: A frame landing in an owned descriptor (status bit 31 = 1) is written to its buffer in byte order, little-endian within each 32-bit word, and only the byte lanes that hold frame bytes are enabled.
- R3: Write-back status has bit 31 = 0, bit 30 equal to the fetched end-of-ring bit, bits 29 and 28 both 1, and bits 12:0 equal to the stored byte count including the 4-byte CRC.
- R4: Write-back error bits: bit 19 = the input error flag was seen, bit 20 = frame shorter than 64 bytes, bit 22 = frame exceeded the buffer, and bit 21 = OR of those three.
- R5: The buffer capacity is status bits 12:0 at hand-off. Bytes beyond it are accepted and discarded, so the stored length never exceeds it.
- R6: After a frame the pointer moves to the next descriptor 16 bytes on. After a descriptor with bit 30 set it returns to the ring base, whose bits 7:0 are ignored (256-byte alignment).
- R7: A frame arriving while the current descriptor has bit 31 = 0 is consumed without any memory write. The saturating missed counter increments, interrupt bit 2 is raised, and the pointer does not move.
- R8: Interrupt bit 0 is set by an error-free write-back and bit 1 by a write-back with bit 21 set. Each bit stays set until a 1 is written to the same position of irq_clr.
- R9: While enable is 0 and the engine sits between frames, in_ready stays 0, no memory request is made, and the pointer reloads from the ring base.
- R10: A memory request keeps its address, direction and write data unchanged until it is acknowledged.
- R11: After reset, interrupt status, the missed counter, in_ready and mem_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Engine enable |
| ring_base | input | AW+2 | Ring base byte address (bits 7:0 ignored) |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Last byte of frame |
| in_err | input | 1 | Frame error flag (CRC) |
| in_ready | output | 1 | Engine accepts the byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completed |
| irq_clr | input | 3 | Write-1-to-clear for irq_status |
| irq_status | output | 3 | Bit 0 good frame, bit 1 errored frame, bit 2 missed frame |
| missed_count | output | MISS_W | Saturating missed-frame count |

## Verification
The embedded properties check every cycle that a pending memory request holds steady and that the input and memory sides never run at once. They also check that the written-back length never exceeds the buffer capacity, that a wrap lands exactly on the aligned base, and that the missed counter only moves together with the missed interrupt. Byte placement, exact status encodings, the drop path that leaves the pointer in place, and the reload on re-enable can only be shown by the bench's frame scenarios, which compare memory contents against values the bench computes itself.

// File: rtl/rx_ring_engine.sv
module rx_ring_engine #(
  parameter int AW       = 30,
  parameter int MISS_W   = 16,
  parameter int RUNT_MIN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [AW+1:0]     ring_base,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              in_err,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  input  logic [2:0]        irq_clr,
  output logic [2:0]        irq_status,
  output logic [MISS_W-1:0] missed_count
);
  typedef enum logic [2:0] {
    S_IDLE, S_RD_STAT, S_RD_BUF, S_RECV, S_WR_DATA, S_WR_STAT, S_DROP
  } st_t;

  st_t             state;
  logic [AW-1:0]   cur, buf_w;
  logic            desc_eor, trunc, ferr, last_seen;
  logic [12:0]     buf_size, stored, total;
  logic [31:0]     wbuf;
  logic [3:0]      wbe;
  logic [2:0]      irq_set;

  wire [AW-1:0] base_w = {ring_base[AW+1:8], 6'd0};
  wire          acc    = in_valid && in_ready;
  wire          store  = stored < buf_size;
  wire [1:0]    lane   = stored[1:0];
  wire          full   = (lane == 2'd3) || in_last || (stored + 13'd1 == buf_size);
  wire          runt   = total < 13'(RUNT_MIN);
  wire          summ   = ferr || runt || trunc;
  wire [31:0]   stat_w = {1'b0, desc_eor, 2'b11, 5'd0, trunc, summ, runt, ferr, 6'd0, stored};

  assign in_ready = (state == S_RECV) || (state == S_DROP);
  assign mem_req  = (state == S_RD_STAT) || (state == S_RD_BUF) ||
                    (state == S_WR_DATA) || (state == S_WR_STAT);
  assign mem_we   = (state == S_WR_DATA) || (state == S_WR_STAT);
  assign mem_be   = (state == S_WR_DATA) ? wbe : 4'hF;

  always_comb begin
    mem_addr  = cur;
    mem_wdata = 32'd0;
    case (state)
      S_RD_BUF:  mem_addr = cur + AW'(2);
      S_WR_DATA: begin
        mem_addr  = buf_w + AW'((stored - 13'd1) >> 2);
        mem_wdata = wbuf;
      end
      S_WR_STAT: mem_wdata = stat_w;
      default: ;
    endcase
  end

  always_comb begin
    irq_set    = 3'd0;
    irq_set[0] = (state == S_WR_STAT) && mem_ack && !summ;
    irq_set[1] = (state == S_WR_STAT) && mem_ack && summ;
    irq_set[2] = (state == S_DROP) && acc && in_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      cur          <= '0;
      buf_w        <= '0;
      desc_eor     <= 1'b0;
      buf_size     <= '0;
      stored       <= '0;
      total        <= '0;
      trunc        <= 1'b0;
      ferr         <= 1'b0;
      last_seen    <= 1'b0;
      wbuf         <= '0;
      wbe          <= '0;
      irq_status   <= '0;
      missed_count <= '0;
    end else begin
      irq_status <= (irq_status & ~irq_clr) | irq_set;
      if (irq_set[2] && missed_count != '1) missed_count <= missed_count + 1'b1;
      case (state)
        S_IDLE: begin
          if (!enable) cur <= base_w;
          else if (in_valid) begin
            state     <= S_RD_STAT;
            stored    <= '0;
            total     <= '0;
            trunc     <= 1'b0;
            ferr      <= 1'b0;
            last_seen <= 1'b0;
            wbuf      <= '0;
            wbe       <= '0;
          end
        end
        S_RD_STAT: if (mem_ack) begin
          if (mem_rdata[31]) begin
            desc_eor <= mem_rdata[30];
            buf_size <= mem_rdata[12:0];
            state    <= S_RD_BUF;
          end else state <= S_DROP;
        end
        S_RD_BUF: if (mem_ack) begin
          buf_w <= mem_rdata[AW+1:2];
          state <= S_RECV;
        end
        S_RECV: if (acc) begin
          if (total != '1) total <= total + 13'd1;
          ferr      <= ferr | in_err;
          last_seen <= in_last;
          if (store) begin
            wbuf[lane*8 +: 8] <= in_data;
            wbe[lane]         <= 1'b1;
            stored            <= stored + 13'd1;
            if (full) state <= S_WR_DATA;
          end else begin
            trunc <= 1'b1;
            if (in_last) state <= S_WR_STAT;
          end
        end
        S_WR_DATA: if (mem_ack) begin
          wbuf  <= '0;
          wbe   <= '0;
          state <= last_seen ? S_WR_STAT : S_RECV;
        end
        S_WR_STAT: if (mem_ack) begin
          cur   <= desc_eor ? base_w : cur + AW'(4);
          state <= S_IDLE;
        end
        S_DROP: if (acc && in_last) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_side_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mem_req);

  p_len_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR_STAT) |-> (mem_wdata[12:0] <= buf_size));

  p_wrap_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR_STAT && mem_ack && desc_eor) |=> (cur == $past(base_w)));

  p_missed_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (missed_count != $past(missed_count)) |-> irq_status[2]);

  p_irq_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_set));
endmodule

// File: tb/rx_ring_engine_tb.sv
module rx_ring_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 30;
  localparam int NV = 5;
  localparam int T_DESC [NV] = '{0, 1, 2, 3, 0};
  localparam int T_LEN  [NV] = '{70, 64, 40, 100, 67};
  localparam int T_SIZE [NV] = '{128, 128, 128, 90, 128};
  localparam int T_ERR  [NV] = '{0, 1, 0, 0, 0};
  localparam int T_EOR  [NV] = '{0, 0, 0, 1, 0};
  localparam int T_NEW  [NV] = '{1, 1, 1, 1, 0};

  logic clk = 0, rst_n = 0, enable = 0;
  logic [AW+1:0] ring_base = 32'h2C5;
  logic in_valid = 0, in_last = 0, in_err = 0;
  logic [7:0] in_data = 0;
  logic in_ready, mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic [2:0] irq_clr = 0, irq_status;
  logic [15:0] missed_count;

  logic [31:0] mem [1024];
  logic hw_en = 0;
  logic [9:0] hw_addr = 0;
  logic [31:0] hw_data = 0;
  logic pend_q;
  logic [AW-1:0] pend_addr;
  int hold_err = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_engine #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ring_base(ring_base),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
    .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .irq_clr(irq_clr), .irq_status(irq_status), .missed_count(missed_count));

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= 32'hEEEEEEEE;
      mem_ack <= 0;
      mem_rdata <= 0;
      pend_q <= 0;
    end else begin
      if (hw_en) mem[hw_addr] <= hw_data;
      if (mem_req && mem_ack && mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      mem_rdata <= mem[mem_addr[9:0]];
      mem_ack   <= mem_req && !mem_ack;
      if (pend_q && mem_addr != pend_addr) hold_err <= hold_err + 1;
      pend_q    <= mem_req && !mem_ack;
      pend_addr <= mem_addr;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input int waddr, input logic [31:0] d);
    @(negedge clk);
    hw_en = 1; hw_addr = waddr[9:0]; hw_data = d;
    @(negedge clk);
    hw_en = 0;
  endtask

  function automatic logic [7:0] pat(input int k, input int seed);
    return 8'((k * 7 + seed * 13) & 255);
  endfunction

  function automatic int dwa(input int d);
    return 32'h80 + 4 * d;
  endfunction

  function automatic int bwa(input int d);
    return (32'h400 + 32'h100 * d) / 4;
  endfunction

  function automatic logic [7:0] rdbyte(input int d, input int k);
    return mem[bwa(d) + k / 4][(k % 4) * 8 +: 8];
  endfunction

  task automatic arm(input int d, input int size, input bit eor);
    host_wr(dwa(d), {1'b1, eor, 17'd0, 13'(size)});
    host_wr(dwa(d) + 2, 32'h400 + 32'h100 * d);
  endtask

  task automatic send_frame(input int len, input bit err, input int seed);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1; in_data = pat(k, seed); in_last = (k == len - 1); in_err = err && (k == len - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0; in_err = 0;
    repeat (10) @(negedge clk);
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 3'b111;
    @(negedge clk); irq_clr = 3'b000;
  endtask

  task automatic check_frame(input int d, input int len, input int size, input bit err,
                             input bit eor, input int seed, input bit fresh);
    int st;
    bit tr, rn, sm, ok;
    logic [31:0] exp;
    st = (len < size) ? len : size;
    tr = len > size;
    rn = len < 64;
    sm = tr | rn | err;
    exp = {1'b0, eor, 2'b11, 5'd0, tr, sm, rn, err, 6'd0, 13'(st)};
    chk(mem[dwa(d)][31:28] == exp[31:28] && mem[dwa(d)][12:0] == exp[12:0],
        "R3 write-back ownership/length", mem[dwa(d)], exp);
    chk(mem[dwa(d)][22:19] == exp[22:19], "R4 error bits", mem[dwa(d)], exp);
    ok = 1;
    for (int k = 0; k < st; k++) if (rdbyte(d, k) != pat(k, seed)) ok = 0;
    chk(ok, "R1 R2 buffer contents", 32'(ok), 32'd1);
    if (fresh && (st % 4) != 0)
      chk(rdbyte(d, st) == 8'hEE, "R2 R5 byte past end untouched", 32'(rdbyte(d, st)), 32'hEE);
    chk(irq_status[1:0] == {sm, !sm}, "R8 irq status", 32'(irq_status), 32'({sm, !sm}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] saved;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(irq_status == 0 && missed_count == 0, "R11 reset irq/missed", 32'({irq_status, missed_count}), 0);
    chk(!in_ready && !mem_req, "R11 reset handshake", 32'({in_ready, mem_req}), 0);

    enable = 1;
    for (int v = 0; v < NV; v++) begin
      arm(T_DESC[v], T_SIZE[v], T_EOR[v] != 0);
      send_frame(T_LEN[v], T_ERR[v] != 0, v + 1);
      check_frame(T_DESC[v], T_LEN[v], T_SIZE[v], T_ERR[v] != 0, T_EOR[v] != 0, v + 1, T_NEW[v] != 0);
      clear_irq();
      chk(irq_status == 0, "R8 write-1-to-clear", 32'(irq_status), 0);
    end

    // R7: descriptor 1 is still owned by software after the wrap (R6)
    saved = mem[dwa(1)];
    send_frame(20, 0, 9);
    chk(missed_count == 1, "R7 missed count", 32'(missed_count), 1);
    chk(irq_status == 3'b100, "R7 missed irq", 32'(irq_status), 32'b100);
    chk(mem[dwa(1)] == saved && rdbyte(1, 0) == pat(0, 2), "R7 no memory write", mem[dwa(1)], saved);
    send_frame(30, 0, 10);
    chk(missed_count == 2, "R7 missed count second", 32'(missed_count), 2);
    clear_irq();
    arm(1, 128, 0);
    send_frame(72, 0, 11);
    check_frame(1, 72, 128, 0, 0, 11, 0);
    clear_irq();

    // R9: disabled engine idles and reloads the base
    @(negedge clk); enable = 0;
    arm(0, 128, 0);
    @(negedge clk); in_valid = 1; in_data = 8'h55;
    begin
      bit quiet = 1;
      repeat (8) begin @(negedge clk); if (in_ready || mem_req) quiet = 0; end
      chk(quiet, "R9 disabled keeps ready and request low", 32'(quiet), 1);
    end
    in_valid = 0;
    @(negedge clk); enable = 1;
    send_frame(65, 0, 12);
    check_frame(0, 65, 128, 0, 0, 12, 0);
    clear_irq();

    chk(hold_err == 0, "R10 request held until ack", 32'(hold_err), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule